// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block takes in serial words whose bit clock comes from an external master. The serial clock and data lines are brought into the system clock domain through a short synchronizer. One data bit is captured on each falling edge of the synchronized serial clock, with the least significant bit first. A word is 8 bits long, or 9 bits long when software asks for it. When the last bit arrives, the word moves into a single holding register and a completion flag is set.

Software uses a small register interface. The control register enables the port and picks the mode. The status register returns the completion flag, the overrun flag and the ninth data bit. The data register returns the low eight bits, and reading it consumes the word. If a new word finishes while the held word is still unread, the new word is discarded and the overrun flag is set. Reception then stays frozen until software drops the continuous-receive enable. Dropping that enable is the only way to clear the error, and it also throws away any partly shifted word. An interrupt request follows the completion flag whenever the receive interrupt enable is set.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the done flag (status bit 0) and overrun flag (status bit 1) read 0, and irq is low.
- R2: A word is received only when all three of these hold: port enable (control bit 0) is 1, sync mode (control bit 1) is 1, and master clock select (control bit 2) is 0. If any one of them fails, a word sent on the serial pins leaves the done flag at 0.
- R3: Reception requires continuous receive (control bit 4). The single-shot bit (control bit 5) is ignored: with it set and bit 4 clear, no word completes.
- R4: With 9-bit mode (control bit 3) clear, the eight bits sampled on consecutive falling serial-clock edges are placed LSB first, and reading the data register (address 2) returns them.
- R5: With control bit 3 set, a word is nine bits long. The first eight bits appear in the data register and the ninth bit appears in status bit 2.
- R6: Completing a word sets the done flag. A read of the data register clears it.
- R7: irq is high exactly while the done flag is set and the interrupt enable (control bit 6) is set.
- R8: If a word completes while the done flag is still set, the overrun flag is set and the held data is unchanged. Later words are not received: the done flag stays clear after the data is read.
- R9: Clearing control bit 4 clears the overrun flag and discards a partly received word. The next full word is then received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the external master, idle high |
| ser_dat | input | 1 | Serial data line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data-register read consumes the word) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The hardest state to reach from the ports is the frozen overrun condition. Reaching it requires two complete words with no data read in between. The bench must then show that a third word is truly ignored, and the only way to see that from outside is that the done flag stays clear after the held word is drained. A second hard case is a word cut off part-way by dropping the enable. The stimulus sends only a few bits, toggles the enable, and then sends a full word whose value would be corrupted if any stale bit or count had survived. Random words of random length are interleaved with these directed sequences.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  // control register layout, msb first
  typedef struct packed {
    logic rsvd;
    logic irq_en;
    logic single_rx;
    logic cont_rx;
    logic word9;
    logic clk_master;
    logic sync_mode;
    logic port_en;
  } ctrl_t;
endpackage

// File: rtl/ssrx_rst_sync.sv
module ssrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb chain_n = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ssrx_line_sync.sv
module ssrx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic dat_s,
  output logic fall_s
);
  logic [STAGES:0]   sclk_q, sclk_n;
  logic [STAGES-1:0] sdat_q, sdat_n;

  always_comb begin
    sclk_n = {sclk_q[STAGES-1:0], ser_clk};
    sdat_n = {sdat_q[STAGES-2:0], ser_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      sdat_q <= '0;
    end else begin
      sclk_q <= sclk_n;
      sdat_q <= sdat_n;
    end
  end

  // serial clock and data share the same synchronizer depth
  assign fall_s = sclk_q[STAGES] & ~sclk_q[STAGES-1];
  assign dat_s  = sdat_q[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                flush,
  input  logic                word9,
  input  logic                fall,
  input  logic                din,
  output logic                word_valid,
  output logic [MAX_BITS-1:0] word
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(MAX_BITS - 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(MAX_BITS - 2);

  logic [MAX_BITS-1:0] sh_q, sh_n, merged;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [CNT_W-1:0]    last_idx;

  always_comb begin
    last_idx   = word9 ? LAST9 : LAST8;
    merged     = sh_q;
    merged[cnt_q] = din;
    sh_n       = sh_q;
    cnt_n      = cnt_q;
    word_valid = 1'b0;
    if (flush) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (run && fall) begin
      if (cnt_q == last_idx) begin
        word_valid = 1'b1;
        sh_n       = '0;
        cnt_n      = '0;
      end else begin
        sh_n  = merged;
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign word = merged;
endmodule

// File: rtl/ssrx_regs.sv
module ssrx_regs
  import ssrx_pkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                word_valid,
  input  logic [MAX_BITS-1:0] word,
  output ctrl_t               ctrl_q,
  output logic                done_q,
  output logic                ovr_q,
  output logic [REG_W-1:0]    data_q,
  output logic                rd_data_hit,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq
);
  ctrl_t ctrl_n;
  logic  done_n, ovr_n, load_en;
  logic  ninth_q;

  always_comb begin
    rd_data_hit = reg_rd && (reg_addr == A_DATA);
    ctrl_n  = ctrl_q;
    done_n  = done_q;
    ovr_n   = ovr_q;
    load_en = 1'b0;
    if (reg_wr && reg_addr == A_CTRL) begin
      ctrl_n      = ctrl_t'(reg_wdata);
      ctrl_n.rsvd = 1'b0;
    end
    if (!ctrl_q.cont_rx) ovr_n = 1'b0;
    if (word_valid) begin
      if (done_q && !rd_data_hit) begin
        ovr_n = 1'b1;
      end else begin
        load_en = 1'b1;
        done_n  = 1'b1;
      end
    end else if (rd_data_hit) begin
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      done_q <= done_n;
      ovr_q  <= ovr_n;
    end
  end

  // holding register: data path only, left without reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q  <= word[REG_W-1:0];
      ninth_q <= word[MAX_BITS-1];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {5'b0, ninth_q, ovr_q, done_q};
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = done_q & ctrl_q.irq_en;
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import ssrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BITS    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic                rst_sync_n;
  logic                dat_s, fall_s;
  logic                word_valid;
  logic [MAX_BITS-1:0] word;
  ctrl_t               ctrl_q;
  logic                done_q, ovr_q, rd_data_hit;
  logic [REG_W-1:0]    data_q;
  logic                active, cont_rx;

  assign cont_rx = ctrl_q.cont_rx;
  assign active  = ctrl_q.port_en & ctrl_q.sync_mode & ~ctrl_q.clk_master & cont_rx;

  ssrx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  ssrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dat_s(dat_s), .fall_s(fall_s));

  ssrx_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .run(active & ~ovr_q), .flush(~cont_rx),
    .word9(ctrl_q.word9), .fall(fall_s), .din(dat_s),
    .word_valid(word_valid), .word(word));

  ssrx_regs #(.MAX_BITS(MAX_BITS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .word_valid(word_valid),
    .word(word), .ctrl_q(ctrl_q), .done_q(done_q), .ovr_q(ovr_q),
    .data_q(data_q), .rd_data_hit(rd_data_hit), .reg_rdata(reg_rdata),
    .irq(irq));
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cont_rx,
  input logic       active,
  input logic       word_valid,
  input logic       rd_data_hit,
  input logic       done_q,
  input logic       ovr_q,
  input logic       irq,
  input logic [7:0] data_q
);
  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !word_valid); // R2
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !done_q) |=> done_q); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_hit && !word_valid) |=> !done_q); // R6
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && cont_rx) |=> ovr_q); // R8
  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !word_valid); // R8
  AST_OVR_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(data_q)); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_rx |=> !ovr_q); // R9
endmodule

bind sync_slave_rx ssrx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cont_rx(cont_rx), .active(active),
  .word_valid(word_valid), .rd_data_hit(rd_data_hit), .done_q(done_q),
  .ovr_q(ovr_q), .irq(irq), .data_q(data_q));

// File: tb/sim_sync_slave_rx.sv
module sim_sync_slave_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b1;
  logic       ser_dat = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam int HALF = 4;

  always #5 clk = ~clk;

  sync_slave_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // control encoding: b0 port, b1 sync, b2 master clk, b3 nine-bit,
  // b4 continuous, b5 single-shot, b6 irq enable
  function automatic logic [7:0] cfg(input bit nine, input bit ien);
    return 8'h13 | (nine ? 8'h08 : 8'h00) | (ien ? 8'h40 : 8'h00);
  endfunction

  function automatic logic [7:0] exp_low(input logic [8:0] v);
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_bits(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_dat = v[i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [8:0] w;
    bit nine;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", {1'b0, d}, 9'h000);
    rd(2'd1, d); check("R1 flags", {7'b0, d[1:0]}, 9'h000);
    check("R1 irq", {8'b0, irq}, 9'h000);

    // R2 master clock select blocks reception
    wr(2'd0, 8'h17);
    send_bits(9'h03C, 8);
    rd(2'd1, d); check("R2 master", {8'b0, d[0]}, 9'h000);
    // R2 port disabled
    wr(2'd0, 8'h12);
    send_bits(9'h03C, 8);
    rd(2'd1, d); check("R2 port off", {8'b0, d[0]}, 9'h000);

    // R3 single-shot bit alone does nothing
    wr(2'd0, 8'h23);
    send_bits(9'h0C3, 8);
    rd(2'd1, d); check("R3 single", {8'b0, d[0]}, 9'h000);

    // R4, R6, R7 basic 8-bit word
    wr(2'd0, cfg(0, 0));
    send_bits(9'h0A6, 8);
    rd(2'd1, d); check("R6 done set", {8'b0, d[0]}, 9'h001);
    check("R7 irq masked", {8'b0, irq}, 9'h000);
    rd(2'd2, d); check("R4 data", {1'b0, d}, {1'b0, exp_low(9'h0A6)});
    rd(2'd1, d); check("R6 read clears", {8'b0, d[0]}, 9'h000);

    // R5 nine-bit word
    wr(2'd0, cfg(1, 0));
    send_bits(9'h15A, 9);
    rd(2'd1, d); check("R5 ninth", {8'b0, d[2]}, 9'h001);
    rd(2'd2, d); check("R5 data", {1'b0, d}, 9'h05A);

    // R7 interrupt
    wr(2'd0, cfg(0, 1));
    send_bits(9'h081, 8);
    check("R7 irq high", {8'b0, irq}, 9'h001);
    rd(2'd2, d);
    @(negedge clk);
    check("R7 irq low", {8'b0, irq}, 9'h000);

    // R8 overrun
    wr(2'd0, cfg(0, 0));
    send_bits(9'h011, 8);
    send_bits(9'h0EE, 8);
    rd(2'd1, d); check("R8 ovr set", {7'b0, d[1:0]}, 9'h003);
    rd(2'd2, d); check("R8 data kept", {1'b0, d}, 9'h011);
    send_bits(9'h077, 8);
    rd(2'd1, d); check("R8 frozen", {7'b0, d[1:0]}, 9'h002);

    // R9 clear by dropping enable, partial word discarded
    wr(2'd0, 8'h03);
    rd(2'd1, d); check("R9 ovr clear", {8'b0, d[1]}, 9'h000);
    wr(2'd0, cfg(0, 0));
    send_bits(9'h1FF, 3);
    wr(2'd0, 8'h03);
    wr(2'd0, cfg(0, 0));
    send_bits(9'h024, 8);
    rd(2'd1, d); check("R9 done after flush", {7'b0, d[1:0]}, 9'h001);
    rd(2'd2, d); check("R9 data", {1'b0, d}, 9'h024);

    // random words, random length (R4, R5)
    for (int k = 0; k < 24; k++) begin
      nine = $urandom_range(0, 1);
      w = 9'($urandom);
      if (!nine) w[8] = 1'b0;
      wr(2'd0, cfg(nine, 0));
      send_bits(w, nine ? 9 : 8);
      rd(2'd1, d);
      check("R5 rnd flags", {7'b0, d[1:0]}, 9'h001);
      if (nine) check("R5 rnd ninth", {8'b0, d[2]}, {8'b0, w[8]});
      rd(2'd2, d);
      check("R4 rnd data", {1'b0, d}, {1'b0, exp_low(w)});
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule